// File: doc/BRIEF.md
# One-Time Fuse Program and Read Sequencer

This block controls a small one-time-programmable fuse array. The array is split into four blocks: the first holds seven 32-bit words and the other three hold eight words each. Software reaches the block through a simple register port. It stages the bits it wants to burn in a bank of write-staging registers. It arms an operation by writing a 16-bit key to a configuration register, then starts it by writing an operation code to a command register.

A program operation visits every fuse word in turn and ORs the staged bits into the stored contents, so a fuse bit can be set but never cleared. A read operation visits every word and copies the fuse contents into a bank of read-back registers. Software follows each program operation with a read operation, because programming does not refresh the read-back bank. The time spent on each word comes from two fields of a timing register. Their reset values are chosen from a bus-clock frequency parameter, and software may rewrite them. The command register reads back its code while the walk is running and returns to zero when it ends, so software polls it to wait.

Top module: `fuse_otp_ctrl`

## Requirements
- R1: After reset the following registers read 0: the configuration, the command, every staging word and every read-back word. The timing register reads {div, hold, setup} = {100, 128, 80}, which is 0x00648050, when BUS_MHZ is above 40. It reads {80, 255, 160} when BUS_MHZ is 27 to 40, and {52, 255, 250} when BUS_MHZ is 26 or less.
- R2: Addresses are in bytes and aligned to 4. Block b, word w has its staging register at 32·b+4·w and its read-back register at 128+32·b+4·w. The configuration register is at 0x100 (bits 15:0), the command register at 0x104 and the timing register at 0x108. The timing fields are setup in bits 7:0, hold in bits 15:8 and div in bits 23:16. Unmapped addresses read 0. Read data is registered and appears one clock after the address.
- R3: Writing command 0x02 while the configuration holds 0x5A5A starts a program operation. Writing 0x01 while it holds 0x5AA5 starts a read operation. While the operation runs, the command register reads back that code, and it reads 0 once the operation ends.
- R4: A command write whose code does not match the armed key is ignored. So is any other code, and so is any command written under any other key. In each of these cases the command register reads 0 on the next read.
- R5: An operation occupies 31·P clocks, where P = max(setup+hold, 2). The first zero read of the command register, polled every clock, comes 31·P+1 clocks after the command write edge.
- R6: A program operation sets each fuse word to its old value OR the staged word. A later program with different bits never clears a set bit.
- R7: When a program operation ends, all staging registers are cleared to 0. A read operation leaves them unchanged.
- R8: A read operation copies every fuse word into its read-back register. A program operation leaves the read-back registers unchanged.
- R9: Block 0 has no word 7. Its staging and read-back slots (0x1C and 0x9C) ignore writes and read 0, and no operation touches a fuse there.
- R10: While an operation runs, writes to the staging, configuration, timing and command registers are ignored.
- R11: Reset does not change the fuse contents. A read operation after reset returns the bits burned before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW (9) | Byte address for reads and writes |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data for the previous cycle's address |

## Verification
The key and command decode is tried with each pairing of the two keys and the two codes, plus a zero key, an unknown code and an unknown key. The result separates a started operation (command reads back its code for the full duration) from an ignored one (command reads 0 at once). The durations are measured with three timing settings, one of them below the two-clock floor, which separates the per-word sum from the floor. The merge is tried with disjoint bits and then with a subset of bits already burned, which tells an OR apart from an overwrite. Scattered words in the first, middle and last slots of several blocks, with an untouched neighbour, catch an address walk that skips or shifts words.

// File: rtl/fuse_otp_pkg.sv
package fuse_otp_pkg;

  localparam logic [15:0] KEY_PROG = 16'h5A5A;
  localparam logic [15:0] KEY_READ = 16'h5AA5;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_READ = 2'd1,
    OP_PROG = 2'd2
  } fuse_op_e;

  // div occupies the top byte, setup the bottom byte
  typedef struct packed {
    logic [7:0] div;
    logic [7:0] hold;
    logic [7:0] setup;
  } fuse_timing_t;

  function automatic fuse_timing_t timing_for_mhz(input int mhz);
    fuse_timing_t t;
    if (mhz <= 26) begin
      t.setup = 8'd250; t.hold = 8'd255; t.div = 8'd52;
    end else if (mhz <= 40) begin
      t.setup = 8'd160; t.hold = 8'd255; t.div = 8'd80;
    end else begin
      t.setup = 8'd80;  t.hold = 8'd128; t.div = 8'd100;
    end
    return t;
  endfunction

endpackage

// File: rtl/fuse_seq_ctrl.sv
module fuse_seq_ctrl #(
  parameter int NBLK       = 4,
  parameter int WPB        = 8,
  parameter int BLK0_WORDS = 7,
  parameter int PER_W      = 9,
  localparam int BLK_W     = $clog2(NBLK),
  localparam int WRD_W     = $clog2(WPB)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PER_W-1:0] period,
  output logic             busy,
  output logic             word_done,
  output logic             last_done,
  output logic [BLK_W-1:0] blk,
  output logic [WRD_W-1:0] wrd
);

  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] per_eff;
  logic             busy_q;
  logic [BLK_W-1:0] blk_q;
  logic [WRD_W-1:0] wrd_q;
  logic             wrd_last;

  // a word needs at least two clocks: one to fetch, one to merge
  assign per_eff   = (period < PER_W'(2)) ? PER_W'(2) : period;
  assign wrd_last  = (blk_q == '0) ? (wrd_q == WRD_W'(BLK0_WORDS - 1))
                                   : (wrd_q == WRD_W'(WPB - 1));
  assign word_done = busy_q && (cnt_q == per_eff - PER_W'(1));
  assign last_done = word_done && wrd_last && (blk_q == BLK_W'(NBLK - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      blk_q  <= '0;
      wrd_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        blk_q  <= '0;
        wrd_q  <= '0;
      end
    end else if (word_done) begin
      cnt_q <= '0;
      if (last_done) begin
        busy_q <= 1'b0;
      end else if (wrd_last) begin
        blk_q <= blk_q + BLK_W'(1);
        wrd_q <= '0;
      end else begin
        wrd_q <= wrd_q + WRD_W'(1);
      end
    end else begin
      cnt_q <= cnt_q + PER_W'(1);
    end
  end

  assign busy = busy_q;
  assign blk  = blk_q;
  assign wrd  = wrd_q;

  // R9: the walk never visits the missing slot of block 0
  a_r9_blk0_span: assert property (@(posedge clk) disable iff (rst)
    (busy_q && blk_q == '0) |-> (wrd_q < WRD_W'(BLK0_WORDS)));

  // R5: the word address stays put until its period completes
  a_r5_word_hold: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !word_done) |=> ($stable(blk_q) && $stable(wrd_q)));

  // R10: a start request while running does not restart the walk
  a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !word_done && start) |=> (cnt_q == $past(cnt_q) + PER_W'(1)));

endmodule

// File: rtl/fuse_array.sv
module fuse_array #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          set_en,
  input  logic [DW-1:0] set_bits,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  // a blank array is all zero; reset never touches it
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    rd_q <= mem[addr];
    if (set_en) mem[addr] <= rd_q | set_bits;
  end

  assign rd_data = rd_q;

  // R6: a merge keeps every bit the word already had
  a_r6_bits_kept: assert property (@(posedge clk) disable iff (rst)
    set_en |=> ((mem[$past(addr)] & $past(rd_q)) == $past(rd_q)));

endmodule

// File: rtl/fuse_otp_ctrl.sv
module fuse_otp_ctrl
  import fuse_otp_pkg::*;
#(
  parameter int NBLK       = 4,
  parameter int WPB        = 8,
  parameter int BLK0_WORDS = 7,
  parameter int DW         = 32,
  parameter int AW         = 9,
  parameter int BUS_MHZ    = 80
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata
);

  localparam int BLK_W      = $clog2(NBLK);
  localparam int WRD_W      = $clog2(WPB);
  localparam int IDX_W      = BLK_W + WRD_W;
  localparam int SLOTS      = NBLK * WPB;
  localparam int BANK_BYTES = SLOTS * 4;
  localparam int PER_W      = 9;
  localparam logic [AW-1:0] CFG_ADDR = AW'(2 * BANK_BYTES);
  localparam logic [AW-1:0] CMD_ADDR = AW'(2 * BANK_BYTES + 4);
  localparam logic [AW-1:0] TIM_ADDR = AW'(2 * BANK_BYTES + 8);

  logic [DW-1:0] wd_q [SLOTS];
  logic [DW-1:0] rb_q [SLOTS];
  logic [15:0]   cfg_q;
  fuse_op_e      cmd_q;
  fuse_timing_t  tim_q;
  logic [SLOTS-1:0] slot_ok;

  logic             busy, word_done, last_done;
  logic [BLK_W-1:0] blk;
  logic [WRD_W-1:0] wrd;
  logic [IDX_W-1:0] walk_idx;
  logic [DW-1:0]    arr_rd;
  logic [PER_W-1:0] period;

  logic [IDX_W-1:0] a_slot;
  logic in_wd, in_rb, cmd_wr, go_prog, go_read;

  // slots beyond the end of a short block do not exist
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign slot_ok[s] = ((s / WPB) != 0) || ((s % WPB) < BLK0_WORDS);
  end

  assign a_slot  = bus_addr[IDX_W+1:2];
  assign in_wd   = bus_addr[AW-1:IDX_W+2] == (AW-IDX_W-2)'(0);
  assign in_rb   = bus_addr[AW-1:IDX_W+2] == (AW-IDX_W-2)'(1);
  assign cmd_wr  = bus_we && !busy && (bus_addr == CMD_ADDR);
  assign go_prog = cmd_wr && (bus_wdata == DW'(OP_PROG)) && (cfg_q == KEY_PROG);
  assign go_read = cmd_wr && (bus_wdata == DW'(OP_READ)) && (cfg_q == KEY_READ);

  assign walk_idx = {blk, wrd};
  assign period   = {1'b0, tim_q.setup} + {1'b0, tim_q.hold};

  fuse_seq_ctrl #(
    .NBLK(NBLK), .WPB(WPB), .BLK0_WORDS(BLK0_WORDS), .PER_W(PER_W)
  ) i_seq (
    .clk(clk), .rst(rst), .start(go_prog || go_read), .period(period),
    .busy(busy), .word_done(word_done), .last_done(last_done),
    .blk(blk), .wrd(wrd)
  );

  fuse_array #(.DEPTH(SLOTS), .DW(DW)) i_array (
    .clk(clk), .rst(rst), .addr(walk_idx),
    .set_en(word_done && cmd_q == OP_PROG),
    .set_bits(wd_q[walk_idx]),
    .rd_data(arr_rd)
  );

  // control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      cmd_q <= OP_NONE;
      tim_q <= timing_for_mhz(BUS_MHZ);
    end else begin
      if (bus_we && !busy && bus_addr == CFG_ADDR) cfg_q <= bus_wdata[15:0];
      if (bus_we && !busy && bus_addr == TIM_ADDR) tim_q <= fuse_timing_t'(bus_wdata[23:0]);
      if (go_prog)        cmd_q <= OP_PROG;
      else if (go_read)   cmd_q <= OP_READ;
      else if (last_done) cmd_q <= OP_NONE;
    end
  end

  // staging bank
  always_ff @(posedge clk) begin
    if (rst || (last_done && cmd_q == OP_PROG)) begin
      for (int s = 0; s < SLOTS; s++) wd_q[s] <= '0;
    end else if (bus_we && !busy && in_wd && slot_ok[a_slot]) begin
      wd_q[a_slot] <= bus_wdata;
    end
  end

  // read-back bank
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SLOTS; s++) rb_q[s] <= '0;
    end else if (word_done && cmd_q == OP_READ) begin
      rb_q[walk_idx] <= arr_rd;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst)                          bus_rdata <= '0;
    else if (in_wd)                   bus_rdata <= wd_q[a_slot];
    else if (in_rb)                   bus_rdata <= rb_q[a_slot];
    else if (bus_addr == CFG_ADDR)    bus_rdata <= DW'(cfg_q);
    else if (bus_addr == CMD_ADDR)    bus_rdata <= DW'(cmd_q);
    else if (bus_addr == TIM_ADDR)    bus_rdata <= DW'(tim_q);
    else                              bus_rdata <= '0;
  end

  logic wd_any;
  always_comb begin
    wd_any = 1'b0;
    for (int s = 0; s < SLOTS; s++) wd_any = wd_any | (|wd_q[s]);
  end

  // R3: the command register shows a code exactly while the walk runs
  a_r3_cmd_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cmd_q != OP_NONE));
  a_r3_cmd_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cmd_q == OP_NONE));

  // R4: a command that fails the key check leaves the sequencer idle
  a_r4_key_gate: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !go_prog && !go_read) |=> !busy);

  // R7: staging is empty after a program walk ends
  a_r7_wd_cleared: assert property (@(posedge clk) disable iff (rst)
    (last_done && cmd_q == OP_PROG) |=> !wd_any);

  // R10: key and timing are frozen while running
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(cfg_q) && $stable(tim_q)));

endmodule

// File: tb/test_fuse_otp_ctrl.sv
module test_fuse_otp_ctrl;

  localparam int AW = 9;
  localparam int DW = 32;
  localparam logic [AW-1:0] CFG = 9'h100;
  localparam logic [AW-1:0] CMD = 9'h104;
  localparam logic [AW-1:0] TIM = 9'h108;

  // {key[15:0], command[7:0], starts}
  localparam logic [24:0] VEC [0:6] = '{
    {16'h5A5A, 8'h02, 1'b1},
    {16'h5AA5, 8'h01, 1'b1},
    {16'h5A5A, 8'h01, 1'b0},
    {16'h5AA5, 8'h02, 1'b0},
    {16'h0000, 8'h02, 1'b0},
    {16'h5A5A, 8'h03, 1'b0},
    {16'h1234, 8'h01, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  fuse_otp_ctrl i_fuse_otp_ctrl (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [AW-1:0] wd_at(input int b, input int w);
    return AW'(32 * b + 4 * w);
  endfunction
  function automatic logic [AW-1:0] rb_at(input int b, input int w);
    return AW'(128 + 32 * b + 4 * w);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic br(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_idle(output int n, output logic [31:0] first);
    bus_addr = CMD; n = 0; first = '0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) first = bus_rdata;
    end while (bus_rdata != 0 && n < 20000);
  endtask

  task automatic run_op(input logic [15:0] key, input logic [31:0] code);
    int n; logic [31:0] f;
    bw(CFG, {16'h0, key});
    bw(CMD, code);
    wait_idle(n, f);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, first;
    int n;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    br(TIM, d);         chk("R1 timing default", d, 32'h0064_8050);
    br(CMD, d);         chk("R1 command", d, 0);
    br(CFG, d);         chk("R1 config", d, 0);
    br(wd_at(1, 0), d); chk("R1 staging", d, 0);
    br(rb_at(3, 7), d); chk("R1 read-back", d, 0);
    br(9'h10C, d);      chk("R2 unmapped", d, 0);

    // R2 timing layout
    bw(TIM, 32'h0000_0101);
    br(TIM, d);         chk("R2 timing write", d, 32'h0000_0101);

    // key and command table (P = 2)
    for (int i = 0; i < 7; i++) begin
      bw(CFG, {16'h0, VEC[i][24:9]});
      bw(CMD, {24'h0, VEC[i][8:1]});
      wait_idle(n, first);
      if (VEC[i][0]) begin
        chk("R3 code while busy", first, {24'h0, VEC[i][8:1]});
        chk("R5 duration P=2", n, 63);
      end else begin
        chk("R4 ignored command", first, 0);
        chk("R4 cleared at once", n, 1);
      end
    end

    // R5 other periods
    bw(TIM, 32'h0000_0102);
    run_op(16'h5AA5, 1);
    bw(CMD, 1);
    wait_idle(n, first);
    chk("R5 duration P=3", n, 94);
    bw(TIM, 32'h0000_0000);
    bw(CMD, 1);
    wait_idle(n, first);
    chk("R5 duration floor", n, 63);
    bw(TIM, 32'h0000_0101);

    // R6 R7 R8 merge
    bw(wd_at(1, 0), 32'h0000_00F0);
    run_op(16'h5A5A, 2);
    br(wd_at(1, 0), d); chk("R7 staging cleared", d, 0);
    br(rb_at(1, 0), d); chk("R8 program leaves read-back", d, 0);
    run_op(16'h5AA5, 1);
    br(rb_at(1, 0), d); chk("R8 read copies", d, 32'h0000_00F0);
    bw(wd_at(1, 0), 32'h0000_000F);
    run_op(16'h5A5A, 2);
    run_op(16'h5AA5, 1);
    br(rb_at(1, 0), d); chk("R6 OR merge", d, 32'h0000_00FF);
    bw(wd_at(1, 0), 32'h0000_0003);
    run_op(16'h5A5A, 2);
    run_op(16'h5AA5, 1);
    br(rb_at(1, 0), d); chk("R6 no clear", d, 32'h0000_00FF);

    // R2 scattered words
    bw(wd_at(0, 6), 32'hA5A5_0000);
    bw(wd_at(3, 7), 32'h8000_0001);
    bw(wd_at(2, 3), 32'h1234_5678);
    run_op(16'h5A5A, 2);
    run_op(16'h5AA5, 1);
    br(rb_at(0, 6), d); chk("R2 block0 word6", d, 32'hA5A5_0000);
    br(rb_at(3, 7), d); chk("R2 block3 word7", d, 32'h8000_0001);
    br(rb_at(2, 3), d); chk("R2 block2 word3", d, 32'h1234_5678);
    br(rb_at(0, 5), d); chk("R2 neighbour untouched", d, 0);

    // R9 missing slot
    bw(wd_at(0, 7), 32'hFFFF_FFFF);
    br(wd_at(0, 7), d); chk("R9 staging hole", d, 0);
    run_op(16'h5A5A, 2);
    run_op(16'h5AA5, 1);
    br(rb_at(0, 7), d); chk("R9 read-back hole", d, 0);
    br(rb_at(1, 0), d); chk("R9 next block intact", d, 32'h0000_00FF);

    // R10 writes during a run, R7 read keeps staging
    bw(wd_at(2, 0), 32'h0000_0011);
    bw(CFG, 32'h0000_5AA5);
    bw(CMD, 1);
    bw(wd_at(2, 0), 32'h0000_0022);
    bw(CFG, 32'h0000_5A5A);
    bw(TIM, 32'h0000_0505);
    bw(CMD, 2);
    wait_idle(n, first);
    chk("R10 command held", first, 1);
    br(wd_at(2, 0), d); chk("R10 staging frozen / R7 kept", d, 32'h0000_0011);
    br(CFG, d);         chk("R10 config frozen", d, 32'h0000_5AA5);
    br(TIM, d);         chk("R10 timing frozen", d, 32'h0000_0101);
    br(rb_at(2, 0), d); chk("R10 no program ran", d, 0);
    bw(wd_at(2, 0), 32'h0);

    // R11 reset keeps fuses
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    br(rb_at(1, 0), d); chk("R1 read-back after reset", d, 0);
    bw(TIM, 32'h0000_0101);
    run_op(16'h5AA5, 1);
    br(rb_at(1, 0), d); chk("R11 fuses persist", d, 32'h0000_00FF);
    br(rb_at(3, 7), d); chk("R11 fuses persist last", d, 32'h8000_0001);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule